// File: doc/BRIEF.md
# Charger Fault Status and Latched Flag Collector

This block gathers the fault conditions of a battery-charger controller and presents them to a host. It handles two fault sources: an input over-voltage condition and a charge safety-timer expiry. For each source it keeps a live status bit that follows the condition. It also keeps a latched flag bit that remembers that the fault happened until the host has read it.

The two sources use different clear-on-read rules. A read of the over-voltage flag clears it only when the over-voltage condition has already gone away. A read of the safety-timer flag clears it even while the timer fault is still asserted. When either fault first appears, the block sends one active-low interrupt pulse of fixed length. The pulse length is a parameterised number of timing ticks; with a 1 µs tick and the default count it lasts 128 µs. A simple register-read strobe with an address stands in for the host's serial bus.

Top module: `chg_fault_flags`

## Requirements
- R1: A synchronous active-high reset clears both status bits and both flags, idles the pulse counter and drives `irq_n_o` high; all of these hold on the first clock edge that samples `rst` high.
- R2: `ovp_stat_o` and `tmr_stat_o` equal their fault inputs as sampled on the previous clock edge. They set and clear with one cycle of latency.
- R3: A rising edge of `ovp_raw_i` sets `ovp_flag_o` one cycle later. The flag stays set after the condition drops.
- R4: A read (`rd_stb_i` high with `rd_addr_i` equal to `OVP_FLAG_ADDR`, default 0x0A) while `ovp_raw_i` is low clears `ovp_flag_o` on the next cycle.
- R5: A read of `OVP_FLAG_ADDR` while `ovp_raw_i` is high leaves `ovp_flag_o` set.
- R6: A rising edge of `tmr_fault_i` sets `tmr_flag_o` one cycle later.
- R7: A read of `TMR_FLAG_ADDR` (default 0x0C) clears `tmr_flag_o` on the next cycle even while `tmr_fault_i` is still high. A fault that stays high does not set the flag again.
- R8: Flags are not changed by a read of any other address, or by an address match while `rd_stb_i` is low.
- R9: If a fault rising edge and a read of that fault's flag fall in the same cycle, the flag is set afterwards.
- R10: A fault rising edge while no pulse is running drives `irq_n_o` low from the next cycle. It returns high on the cycle after the `PULSE_TICKS`-th `tick_i` sampled during the pulse.
- R11: A fault rising edge that arrives during a running pulse neither lengthens nor restarts it, and no second pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovp_raw_i | input | 1 | Live over-voltage condition |
| tmr_fault_i | input | 1 | Safety-timer fault condition |
| rd_stb_i | input | 1 | Host register-read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Address of the register being read |
| tick_i | input | 1 | Timing tick for the interrupt pulse length |
| ovp_stat_o | output | 1 | Live over-voltage status |
| tmr_stat_o | output | 1 | Live safety-timer status |
| ovp_flag_o | output | 1 | Latched over-voltage flag |
| tmr_flag_o | output | 1 | Latched safety-timer flag |
| irq_n_o | output | 1 | Active-low interrupt pulse |

## Verification
Status bits, flags and the interrupt start are all due one clock after the input edge or read that causes them. The pulse end is due one clock after the last counted tick. The bench drives inputs on the falling clock edge. A behavioural model advances on the rising edge from the same sampled inputs, and every output is compared with the model at the next falling edge, so each expected value is read one register stage after its cause. Directed checks wait exactly one falling edge after a stimulus before they compare. They cover the clear rules, same-cycle set-and-read and retrigger during a pulse. A long randomised phase then exercises tick phases and overlapping faults against the model.

// File: rtl/chg_fault_pkg.sv
package chg_fault_pkg;

  // Clear-on-read rule applied by a flag channel
  typedef enum logic [0:0] {
    CLR_ON_READ   = 1'b0,  // read clears regardless of live condition
    CLR_WHEN_GONE = 1'b1   // read clears only when condition is absent
  } clr_rule_e;

  localparam int unsigned NUM_FAULTS = 2;
  localparam int unsigned FLT_OVP    = 0;
  localparam int unsigned FLT_TMR    = 1;

  function automatic clr_rule_e rule_of(input int unsigned idx);
    return (idx == FLT_OVP) ? CLR_WHEN_GONE : CLR_ON_READ;
  endfunction

endpackage

// File: rtl/flag_read_decode.sv
module flag_read_decode
  import chg_fault_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OVP_FLAG_ADDR = 8'h0A,
  parameter logic [ADDR_W-1:0] TMR_FLAG_ADDR = 8'h0C
) (
  input  logic                  rd_stb_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [NUM_FAULTS-1:0] hit_o
);

  localparam logic [ADDR_W-1:0] ADDR_TAB [NUM_FAULTS] = '{OVP_FLAG_ADDR, TMR_FLAG_ADDR};

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_hit
    assign hit_o[g] = rd_stb_i && (rd_addr_i == ADDR_TAB[g]);
  end

endmodule

// File: rtl/fault_edge_latch.sv
module fault_edge_latch
  import chg_fault_pkg::*;
#(
  parameter clr_rule_e RULE = CLR_ON_READ
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic rd_hit_i,
  output logic live_o,
  output logic rise_o,
  output logic flag_o
);

  logic live_q;
  logic flag_q;
  logic clr_req;

  // Edge is seen against the registered copy of the condition
  assign rise_o = cond_i && !live_q;

  if (RULE == CLR_WHEN_GONE) begin : g_gone
    assign clr_req = rd_hit_i && !cond_i;
  end else begin : g_always
    assign clr_req = rd_hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      live_q <= cond_i;
      // a new edge wins over a clear in the same cycle
      if (rise_o)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign live_o = live_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned PULSE_TICKS = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               tick_i,
  output logic               irq_n_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

  logic             irq_n_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q <= 1'b1;
      cnt_q   <= '0;
    end else if (irq_n_q) begin
      // idle: only an idle generator accepts a trigger
      if (|trig_i) begin
        irq_n_q <= 1'b0;
        cnt_q   <= '0;
      end
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        irq_n_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign irq_n_o = irq_n_q;

endmodule

// File: rtl/chg_fault_flags.sv
module chg_fault_flags
  import chg_fault_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OVP_FLAG_ADDR = 8'h0A,
  parameter logic [ADDR_W-1:0] TMR_FLAG_ADDR = 8'h0C,
  parameter int unsigned PULSE_TICKS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovp_raw_i,
  input  logic              tmr_fault_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              tick_i,
  output logic              ovp_stat_o,
  output logic              tmr_stat_o,
  output logic              ovp_flag_o,
  output logic              tmr_flag_o,
  output logic              irq_n_o
);

  logic [NUM_FAULTS-1:0] cond;
  logic [NUM_FAULTS-1:0] hit;
  logic [NUM_FAULTS-1:0] live;
  logic [NUM_FAULTS-1:0] rise;
  logic [NUM_FAULTS-1:0] flag;

  assign cond[FLT_OVP] = ovp_raw_i;
  assign cond[FLT_TMR] = tmr_fault_i;

  flag_read_decode #(
    .ADDR_W       (ADDR_W),
    .OVP_FLAG_ADDR(OVP_FLAG_ADDR),
    .TMR_FLAG_ADDR(TMR_FLAG_ADDR)
  ) u_dec (
    .rd_stb_i (rd_stb_i),
    .rd_addr_i(rd_addr_i),
    .hit_o    (hit)
  );

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_chan
    fault_edge_latch #(
      .RULE(rule_of(g))
    ) u_latch (
      .clk     (clk),
      .rst     (rst),
      .cond_i  (cond[g]),
      .rd_hit_i(hit[g]),
      .live_o  (live[g]),
      .rise_o  (rise[g]),
      .flag_o  (flag[g])
    );
  end

  irq_pulse_gen #(
    .NUM_SRC    (NUM_FAULTS),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_irq (
    .clk    (clk),
    .rst    (rst),
    .trig_i (rise),
    .tick_i (tick_i),
    .irq_n_o(irq_n_o)
  );

  assign ovp_stat_o = live[FLT_OVP];
  assign tmr_stat_o = live[FLT_TMR];
  assign ovp_flag_o = flag[FLT_OVP];
  assign tmr_flag_o = flag[FLT_TMR];

endmodule

// File: rtl/chg_fault_flags_chk.sv
module chg_fault_flags_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OVP_FLAG_ADDR = 8'h0A,
  parameter logic [ADDR_W-1:0] TMR_FLAG_ADDR = 8'h0C,
  parameter int unsigned PULSE_TICKS = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              ovp_raw_i,
  input logic              tmr_fault_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              tick_i,
  input logic              ovp_stat_o,
  input logic              tmr_stat_o,
  input logic              ovp_flag_o,
  input logic              tmr_flag_o,
  input logic              irq_n_o
);

  logic ovp_rd, tmr_rd;
  assign ovp_rd = rd_stb_i && (rd_addr_i == OVP_FLAG_ADDR);
  assign tmr_rd = rd_stb_i && (rd_addr_i == TMR_FLAG_ADDR);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!ovp_flag_o && !tmr_flag_o && !ovp_stat_o && !tmr_stat_o && irq_n_o));

  p_stat_follow_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovp_stat_o == $past(ovp_raw_i)) && (tmr_stat_o == $past(tmr_fault_i)));

  p_ovp_set_r3: assert property (@(posedge clk) disable iff (rst)
    (ovp_raw_i && !ovp_stat_o) |=> ovp_flag_o);

  p_ovp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovp_flag_o && ovp_raw_i) |=> ovp_flag_o);

  p_ovp_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (ovp_rd && !ovp_raw_i) |=> !ovp_flag_o);

  p_tmr_set_r6: assert property (@(posedge clk) disable iff (rst)
    (tmr_fault_i && !tmr_stat_o) |=> tmr_flag_o);

  p_tmr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (tmr_rd && tmr_stat_o) |=> !tmr_flag_o);

  p_no_read_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!ovp_rd && ovp_flag_o) |=> ovp_flag_o);

  p_tmr_no_read_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!tmr_rd && tmr_flag_o) |=> tmr_flag_o);

  p_irq_start_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_n_o && ((ovp_raw_i && !ovp_stat_o) || (tmr_fault_i && !tmr_stat_o))) |=> !irq_n_o);

  p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o && !tick_i) |=> !irq_n_o);

endmodule

bind chg_fault_flags chg_fault_flags_chk #(
  .ADDR_W       (ADDR_W),
  .OVP_FLAG_ADDR(OVP_FLAG_ADDR),
  .TMR_FLAG_ADDR(TMR_FLAG_ADDR),
  .PULSE_TICKS  (PULSE_TICKS)
) u_chk (.*);

// File: tb/chg_fault_flags_tb_top.sv
`timescale 1ns/1ps
module chg_fault_flags_tb_top;

  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_OVP = 8'h0A;
  localparam logic [ADDR_W-1:0] A_TMR = 8'h0C;
  localparam logic [ADDR_W-1:0] A_OTH = 8'h0B;
  localparam int unsigned PT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovp_raw_i = 1'b0, tmr_fault_i = 1'b0, rd_stb_i = 1'b0, tick_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic ovp_stat_o, tmr_stat_o, ovp_flag_o, tmr_flag_o, irq_n_o;

  always #10 clk = ~clk;

  chg_fault_flags #(
    .ADDR_W(ADDR_W), .OVP_FLAG_ADDR(A_OVP), .TMR_FLAG_ADDR(A_TMR), .PULSE_TICKS(PT)
  ) dut_i (
    .clk(clk), .rst(rst), .ovp_raw_i(ovp_raw_i), .tmr_fault_i(tmr_fault_i),
    .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i), .tick_i(tick_i),
    .ovp_stat_o(ovp_stat_o), .tmr_stat_o(tmr_stat_o), .ovp_flag_o(ovp_flag_o),
    .tmr_flag_o(tmr_flag_o), .irq_n_o(irq_n_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  bit m_ovp_live, m_tmr_live, m_ovp_flag, m_tmr_flag, m_busy;
  int m_ticks;
  bit e_ovp, e_tmr;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_ovp_live = 0; m_tmr_live = 0; m_ovp_flag = 0; m_tmr_flag = 0;
      m_busy = 0; m_ticks = 0;
    end else begin
      e_ovp = ovp_raw_i && !m_ovp_live;
      e_tmr = tmr_fault_i && !m_tmr_live;
      if (e_ovp) m_ovp_flag = 1;
      else if (rd_stb_i && rd_addr_i == A_OVP && !ovp_raw_i) m_ovp_flag = 0;
      if (e_tmr) m_tmr_flag = 1;
      else if (rd_stb_i && rd_addr_i == A_TMR) m_tmr_flag = 0;
      if (!m_busy) begin
        if (e_ovp || e_tmr) begin m_busy = 1; m_ticks = 0; end
      end else if (tick_i) begin
        m_ticks++;
        if (m_ticks == PT) begin m_busy = 0; m_ticks = 0; end
      end
      m_ovp_live = ovp_raw_i;
      m_tmr_live = tmr_fault_i;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 ovp_stat vs model", ovp_stat_o, m_ovp_live);
      chk("R2 tmr_stat vs model", tmr_stat_o, m_tmr_live);
      chk("R3 ovp_flag vs model", ovp_flag_o, m_ovp_flag);
      chk("R6 tmr_flag vs model", tmr_flag_o, m_tmr_flag);
      chk("R10 irq_n vs model", irq_n_o, !m_busy);
    end
  end

  // tick source and watchdog
  always @(negedge clk) begin
    cyc++;
    tick_i = (cyc % 3 == 0);
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic stb);
    rd_stb_i = stb; rd_addr_i = a;
    step(1);
    rd_stb_i = 1'b0;
  endtask

  initial begin
    step(4);
    chk("R1 ovp_flag reset", ovp_flag_o, 1'b0);
    chk("R1 tmr_flag reset", tmr_flag_o, 1'b0);
    chk("R1 irq_n reset", irq_n_o, 1'b1);
    chk("R1 ovp_stat reset", ovp_stat_o, 1'b0);
    rst = 1'b0;
    step(2);

    ovp_raw_i = 1'b1; step(1);
    chk("R2 ovp_stat set", ovp_stat_o, 1'b1);
    chk("R3 ovp_flag set", ovp_flag_o, 1'b1);
    chk("R10 irq low after edge", irq_n_o, 1'b0);

    rd(A_OVP, 1'b1);
    chk("R5 ovp_flag kept while present", ovp_flag_o, 1'b1);

    ovp_raw_i = 1'b0; step(1);
    chk("R2 ovp_stat cleared", ovp_stat_o, 1'b0);
    chk("R3 ovp_flag sticky", ovp_flag_o, 1'b1);
    step(30);
    chk("R10 irq back high", irq_n_o, 1'b1);

    rd(A_OTH, 1'b1);
    chk("R8 other addr no effect", ovp_flag_o, 1'b1);
    rd(A_OVP, 1'b0);
    chk("R8 no strobe no effect", ovp_flag_o, 1'b1);
    rd(A_OVP, 1'b1);
    chk("R4 ovp_flag cleared by read", ovp_flag_o, 1'b0);

    tmr_fault_i = 1'b1; step(1);
    chk("R6 tmr_flag set", tmr_flag_o, 1'b1);
    chk("R10 irq low on timer", irq_n_o, 1'b0);
    step(2);
    ovp_raw_i = 1'b1; step(1);
    chk("R11 edge during pulse sets flag", ovp_flag_o, 1'b1);
    chk("R11 pulse still running", irq_n_o, 1'b0);
    step(30);
    chk("R11 no second pulse", irq_n_o, 1'b1);

    rd(A_TMR, 1'b1);
    chk("R7 tmr_flag cleared while active", tmr_flag_o, 1'b0);
    step(5);
    chk("R7 held fault does not re-set", tmr_flag_o, 1'b0);

    tmr_fault_i = 1'b0; step(2);
    tmr_fault_i = 1'b1;
    rd(A_TMR, 1'b1);
    chk("R9 edge wins over read", tmr_flag_o, 1'b1);
    step(30);

    rst = 1'b1; step(1);
    chk("R1 mid-run reset flags", ovp_flag_o | tmr_flag_o, 1'b0);
    chk("R1 mid-run reset irq", irq_n_o, 1'b1);
    rst = 1'b0;
    ovp_raw_i = 1'b0; tmr_fault_i = 1'b0;
    step(2);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 11) == 0) ovp_raw_i = ~ovp_raw_i;
      if ($urandom_range(0, 13) == 0) tmr_fault_i = ~tmr_fault_i;
      rd_stb_i = ($urandom_range(0, 4) == 0);
      case ($urandom_range(0, 2))
        0: rd_addr_i = A_OVP;
        1: rd_addr_i = A_TMR;
        default: rd_addr_i = A_OTH;
      endcase
      step(1);
    end
    rd_stb_i = 1'b0;
    step(2);
    done = 1;
    finish_up();
  end

endmodule